// File: doc/BRIEF.md
# Buffered Write-Through Data Cache Controller

This block sits between a processor and main memory as a direct-mapped data cache. Main memory always holds current data. Every processor store goes to memory. If the line is present, the cached copy is also updated in the same cycle. A store is not made to wait for memory. It is captured in a one-deep posted write buffer, and the processor is released at once. The buffer then drains to memory on its own.

While that posted store is still on its way, loads that hit in the cache are answered in their own request cycle. A second store, or a load that misses, must wait until the buffer has drained. Because memory is never stale, any line can be replaced on a miss with no write-back.

The processor side holds `cpuReq` and its address and data stable until `cpuReady` is seen. `cpuBusy` tells the processor that its request is stalled. The memory side carries one transaction at a time. `memReq` and its attributes stay stable until a one-cycle `memAck`. A line read returns the whole line on `memRline`, with word offset 0 in the least significant bits.

Top module: `wtcCacheCtrl`

## Requirements
- R1: After reset no line is valid, so the first read of any address misses and fetches from memory. The write buffer is empty after reset, so `memReq` and `cpuBusy` are low while the processor is idle.
- R2: Every processor write reaches memory exactly once, with its own address and data. Main memory therefore ends up holding the written value.
- R3: A write that finds the buffer empty completes in its request cycle (`cpuReady` high). From the next cycle a memory write of that address is requested.
- R4: A write that hits updates the cached word. A following read of that address returns the new value without any memory read.
- R5: A write that misses does not allocate a line. A later read of that address misses and fetches the line from memory.
- R6: A read that hits completes in its request cycle, also while a buffered write is still waiting for its acknowledge.
- R7: A write issued while the buffer is occupied stalls with `cpuBusy` high. It completes only in the first cycle after the earlier memory write is acknowledged.
- R8: A read miss issued while the buffer is occupied fetches nothing until the buffered write is acknowledged. Memory sees the write first and the line read after it.
- R9: On a read miss, the line containing the address is read from memory with word offset bits zero. The requested word is returned with `cpuReady` in the acknowledge cycle, and the line is then valid. Another word of that line then hits.
- R10: `memReq`, `memWe`, `memAddr` and `memWdata` stay unchanged from the cycle a request is raised until the cycle it is acknowledged.
- R11: `cpuBusy` is high exactly while a request is present and not completing. This includes every cycle of a line fetch before its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid with `cpuReady` on a read |
| cpuReady | output | 1 | Request completes at this clock edge |
| cpuBusy | output | 1 | Request is stalled |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = word write, 0 = line read |
| memAddr | output | ADDR_W | Word address (line base for reads) |
| memWdata | output | DATA_W | Write data of the buffered store |
| memRline | input | DATA_W*2**OFF_W | Line data for a read, valid with `memAck` |
| memAck | input | 1 | One-cycle acknowledge of the current transaction |

## Verification
The bench builds the block with 8-bit word addresses, 16-bit words, four lines and two words per line. This makes index conflicts easy to reach: addresses 0x10 and 0x18 share a line. A full line is only two words, so same-line hits after a fill are cheap to test. The bench's memory model acknowledges after a few cycles. This keeps a buffered write pending long enough for a read hit to overlap it. It also makes the stall of a second write, and the write-then-fetch ordering on a read miss, visible in the memory's operation log.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_FETCH
  } ctlState_t;

  typedef struct packed {
    logic bufLoad;
    logic bufClear;
    logic wordWrite;
    logic lineFill;
    logic rdFromMem;
    logic drainSel;
  } strobe_t;

endpackage

// File: rtl/wtcDatapath.sv
module wtcDatapath
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [DATA_W-1:0]          cpuWdata,
  input  logic [DATA_W*(2**OFF_W)-1:0] memRline,
  output logic                       hit,
  output logic                       bufValid,
  output logic [DATA_W-1:0]          cpuRdata,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          memWdata
);
  localparam int LINES  = 2 ** IDX_W;
  localparam int WORDS  = 2 ** OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0] reqTag;
  logic [IDX_W-1:0] reqIdx;
  logic [OFF_W-1:0] reqOff;

  assign reqTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx = cpuAddr[OFF_W +: IDX_W];
  assign reqOff = cpuAddr[OFF_W-1:0];

  logic [LINES-1:0]             validAll;
  logic [LINES-1:0][TAG_W-1:0]  tagAll;
  logic [LINES-1:0][LINE_W-1:0] dataAll;

  // One storage slice per line: valid bit, tag and line data.
  for (genvar l = 0; l < LINES; l++) begin : gLine
    logic             validQ;
    logic [TAG_W-1:0] tagQ;
    logic [LINE_W-1:0] lineQ;
    logic             sel;

    assign sel = (reqIdx == IDX_W'(l));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= 1'b0;
      else if (strb.lineFill && sel) validQ <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (strb.lineFill && sel) begin
        tagQ  <= reqTag;
        lineQ <= memRline;
      end else if (strb.wordWrite && sel) begin
        lineQ[reqOff*DATA_W +: DATA_W] <= cpuWdata;
      end
    end

    assign validAll[l] = validQ;
    assign tagAll[l]   = tagQ;
    assign dataAll[l]  = lineQ;
  end

  assign hit = validAll[reqIdx] && (tagAll[reqIdx] == reqTag);

  logic [LINE_W-1:0] curLine;
  logic [DATA_W-1:0] cacheWord;
  logic [DATA_W-1:0] fillWord;

  assign curLine   = dataAll[reqIdx];
  assign cacheWord = curLine[reqOff*DATA_W +: DATA_W];
  assign fillWord  = memRline[reqOff*DATA_W +: DATA_W];
  assign cpuRdata  = strb.rdFromMem ? fillWord : cacheWord;

  // Single-entry posted write buffer.
  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufValid <= 1'b0;
    else if (strb.bufLoad) bufValid <= 1'b1;
    else if (strb.bufClear) bufValid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (strb.bufLoad) begin
      bufAddr <= cpuAddr;
      bufData <= cpuWdata;
    end
  end

  assign memAddr  = strb.drainSel ? bufAddr : {reqTag, reqIdx, {OFF_W{1'b0}}};
  assign memWdata = bufData;

endmodule

// File: rtl/wtcControl.sv
module wtcControl
  import wtc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    cpuWe,
  input  logic    hit,
  input  logic    bufValid,
  input  logic    memAck,
  output strobe_t strb,
  output logic    cpuReady,
  output logic    cpuBusy,
  output logic    memReq,
  output logic    memWe
);
  ctlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    strb          = '0;
    cpuReady      = 1'b0;
    nextState     = state;
    // Draining the buffer always owns the memory port first.
    memReq        = bufValid;
    memWe         = bufValid;
    strb.drainSel = bufValid;
    strb.bufClear = bufValid && memAck;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (cpuWe) begin
            if (!bufValid) begin
              cpuReady       = 1'b1;
              strb.bufLoad   = 1'b1;
              strb.wordWrite = hit;
            end
          end else if (hit) begin
            cpuReady = 1'b1;
          end else if (!bufValid) begin
            nextState = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.lineFill  = 1'b1;
          strb.rdFromMem = 1'b1;
          cpuReady       = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    cpuBusy = cpuReq && !cpuReady;
  end

endmodule

// File: rtl/wtcCacheCtrl.sv
module wtcCacheCtrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReq,
  input  logic                         cpuWe,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [DATA_W-1:0]            cpuWdata,
  output logic [DATA_W-1:0]            cpuRdata,
  output logic                         cpuReady,
  output logic                         cpuBusy,
  output logic                         memReq,
  output logic                         memWe,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [DATA_W-1:0]            memWdata,
  input  logic [DATA_W*(2**OFF_W)-1:0] memRline,
  input  logic                         memAck
);
  strobe_t strb;
  logic    hit;
  logic    bufValid;

  wtcControl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuReq  (cpuReq),
    .cpuWe   (cpuWe),
    .hit     (hit),
    .bufValid(bufValid),
    .memAck  (memAck),
    .strb    (strb),
    .cpuReady(cpuReady),
    .cpuBusy (cpuBusy),
    .memReq  (memReq),
    .memWe   (memWe)
  );

  wtcDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cpuAddr (cpuAddr),
    .cpuWdata(cpuWdata),
    .memRline(memRline),
    .hit     (hit),
    .bufValid(bufValid),
    .cpuRdata(cpuRdata),
    .memAddr (memAddr),
    .memWdata(memWdata)
  );

endmodule

// File: rtl/wtcChecker.sv
module wtcChecker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              cpuBusy,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic              hit,
  input logic              bufValid
);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata));

  assert_write_posted_R3: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && cpuReady |=> bufValid && memReq && memWe);

  assert_hit_no_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuWe && hit |-> cpuReady);

  assert_second_write_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && bufValid |-> cpuBusy && !cpuReady);

  assert_fetch_stalls_cpu_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && !memAck |-> cpuBusy);

endmodule

bind wtcCacheCtrl wtcChecker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReq  (cpuReq),
  .cpuWe   (cpuWe),
  .cpuReady(cpuReady),
  .cpuBusy (cpuBusy),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAddr (memAddr),
  .memWdata(memWdata),
  .memAck  (memAck),
  .hit     (hit),
  .bufValid(bufValid)
);

// File: tb/tb_wtcCacheCtrl.sv
`timescale 1ns/1ps
module tb_wtcCacheCtrl;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 2;
  localparam int OFF_W  = 1;
  localparam int WORDS  = 2 ** OFF_W;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0;
  logic cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic [DATA_W-1:0] cpuRdata;
  logic cpuReady, cpuBusy, memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W*WORDS-1:0] memRline;
  logic memAck = 1'b0;

  always #4 clk = ~clk;

  wtcCacheCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady), .cpuBusy(cpuBusy),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRline(memRline), .memAck(memAck)
  );

  // Memory model with a fixed acknowledge latency and an operation log.
  logic [DATA_W-1:0] mem [0:2**ADDR_W-1];
  int lat = 0;
  int wrCount = 0;
  int rdCount = 0;
  int opN = 0;
  logic opWe [0:63];
  logic [ADDR_W-1:0] opAddr [0:63];
  int holdViol = 0;
  logic pendQ = 1'b0;
  logic [ADDR_W-1:0] pendAddr;
  logic pendWe;
  logic [DATA_W-1:0] pendData;

  function automatic logic [DATA_W-1:0] initVal(input int a);
    return DATA_W'(16'h1000 + a * 7);
  endfunction

  always_comb begin
    for (int w = 0; w < WORDS; w++)
      memRline[w*DATA_W +: DATA_W] = mem[memAddr + ADDR_W'(w)];
  end

  always @(posedge clk) begin
    if (!rstN) begin
      lat <= 0; memAck <= 1'b0; pendQ <= 1'b0;
    end else begin
      memAck <= 1'b0;
      if (pendQ && memReq && (memAddr != pendAddr || memWe != pendWe || (memWe && memWdata != pendData)))
        holdViol <= holdViol + 1;
      pendQ <= memReq && !memAck;
      pendAddr <= memAddr; pendWe <= memWe; pendData <= memWdata;
      if (memReq && !memAck) begin
        if (lat == LAT) begin memAck <= 1'b1; lat <= 0; end
        else lat <= lat + 1;
      end
      if (memReq && memAck) begin
        if (opN < 64) begin opWe[opN] <= memWe; opAddr[opN] <= memAddr; end
        opN <= opN + 1;
        if (memWe) begin mem[memAddr] <= memWdata; wrCount <= wrCount + 1; end
        else rdCount <= rdCount + 1;
      end
    end
  end

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one access; returns read data and the number of stalled cycles.
  task automatic cpuAccess(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           output logic [DATA_W-1:0] rd, output int stall);
    int busyBad;
    busyBad = 0;
    stall = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    #1;
    while (!cpuReady && stall < 200) begin
      if (!cpuBusy) busyBad++;
      @(negedge clk); #1;
      stall++;
    end
    if (cpuBusy) busyBad++;
    rd = cpuRdata;
    check(busyBad == 0, "R11 busy while stalled only", busyBad, 0);
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic waitDrain(input int target);
    for (int i = 0; i < 100 && wrCount < target; i++) @(negedge clk);
    #1;
  endtask

  task automatic tReset();
    #1;
    check(memReq == 1'b0, "R1 memReq after reset", memReq, 0);
    check(cpuBusy == 1'b0, "R1 cpuBusy after reset", cpuBusy, 0);
  endtask

  task automatic tReadMissFill();
    logic [DATA_W-1:0] rd; int st;
    cpuAccess(1'b0, 8'h10, '0, rd, st);
    check(st > 0, "R1 first read misses", st, 1);
    check(rd == initVal(8'h10), "R9 fill returns word", rd, initVal(8'h10));
    check(rdCount == 1 && opAddr[0] == 8'h10, "R9 line base read", opAddr[0], 8'h10);
    cpuAccess(1'b0, 8'h11, '0, rd, st);
    check(st == 0 && rdCount == 1, "R9 other word hits", st, 0);
    check(rd == initVal(8'h11), "R9 other word data", rd, initVal(8'h11));
  endtask

  task automatic tWriteHitOverlap();
    logic [DATA_W-1:0] rd; int st;
    cpuAccess(1'b1, 8'h10, 16'hAAAA, rd, st);
    check(st == 0, "R3 write posted at once", st, 0);
    cpuAccess(1'b0, 8'h10, '0, rd, st);
    check(st == 0 && wrCount == 0, "R6 read hit during drain", wrCount, 0);
    check(rd == 16'hAAAA && rdCount == 1, "R4 hit sees written data", rd, 16'hAAAA);
    waitDrain(1);
    check(wrCount == 1 && mem[8'h10] == 16'hAAAA, "R2 write reaches memory", mem[8'h10], 16'hAAAA);
  endtask

  task automatic tWriteStallAndMiss();
    logic [DATA_W-1:0] rd; int st; int base; int rds;
    base = wrCount;
    cpuAccess(1'b1, 8'h40, 16'h5555, rd, st);
    check(st == 0, "R3 write miss posted", st, 0);
    cpuAccess(1'b1, 8'h42, 16'h6666, rd, st);
    check(st > 0, "R7 second write stalls", st, 1);
    check(wrCount == base + 1, "R7 released after first ack", wrCount, base + 1);
    rds = rdCount;
    cpuAccess(1'b0, 8'h40, '0, rd, st);
    check(rdCount == rds + 1, "R5 write miss not allocated", rdCount, rds + 1);
    check(rd == 16'h5555, "R2 memory current on fetch", rd, 16'h5555);
    check(opWe[opN-2] == 1'b1 && opAddr[opN-2] == 8'h42, "R8 write drains first", opAddr[opN-2], 8'h42);
    check(opWe[opN-1] == 1'b0 && opAddr[opN-1] == 8'h40, "R8 fetch after drain", opAddr[opN-1], 8'h40);
    cpuAccess(1'b0, 8'h41, '0, rd, st);
    check(st == 0 && rd == initVal(8'h41), "R9 filled line hits", rd, initVal(8'h41));
  endtask

  task automatic tReplace();
    logic [DATA_W-1:0] rd; int st; int wb;
    wb = wrCount;
    cpuAccess(1'b0, 8'h18, '0, rd, st);
    check(st > 0 && rd == initVal(8'h18), "R9 conflict miss", rd, initVal(8'h18));
    cpuAccess(1'b0, 8'h10, '0, rd, st);
    check(st > 0 && rd == 16'hAAAA, "R2 replaced line refetched", rd, 16'hAAAA);
    check(wrCount == wb, "R2 no write-back on replace", wrCount, wb);
    check(holdViol == 0, "R10 request held until ack", holdViol, 0);
  endtask

  initial begin
    for (int a = 0; a < 2 ** ADDR_W; a++) mem[a] = initVal(a);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tReadMissFill();
    tWriteHitOverlap();
    tWriteStallAndMiss();
    tReplace();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule